// File: doc/BRIEF.md
# Low-Power Clock Gating Controller

This controller sits between the raw oscillator clock and a small processor core and manages two low-power states. A stop request turns the oscillator off and parks the internal system clock high. A wait request parks the system clock high but keeps the oscillator running. A wait is left at once on an enabled interrupt or on reset.

Leaving stop on an enabled interrupt turns the oscillator back on straight away. The system clock stays parked while a chain made of a prescaler and an 8-bit down-counter times the oscillator warm-up. The clock is released when that chain underflows. By default both counters are loaded with a short fixed warm-up when stop is entered. A configuration input can suppress this preload, so that values written earlier set the warm-up length. Leaving stop through reset skips the warm-up entirely.

The gate is an OR of the oscillator clock and a parking flag. The flag changes only just after a rising edge, so the gated clock never produces a short pulse.

Top module: `lp_clk_ctrl`

## Requirements
- R1: One rising edge after `stop_req` is sampled in run mode, `mode` reads 2'b10 (stop), `osc_en` is 0 and `sys_clk` is held at 1.
- R2: With `keep_cnt` at 0, entering stop loads the timer with 0x01 and the prescaler with 0xFF. An interrupt exit then keeps the clock parked for exactly 512 oscillator edges.
- R3: With `keep_cnt` at 1, entering stop leaves the counters at the values last written through `tmr_wr`/`psc_wr`. The parked span after an interrupt exit is then psc+1+256*tmr edges.
- R4: An enabled interrupt in stop sets `osc_en` to 1 on the next edge. `sys_clk` stays at 1 and `mode` stays 2'b10 until the timer underflows.
- R5: The prescaler decrements on every warm-up edge and wraps from 0x00 to 0xFF, and each wrap decrements the timer. On the edge where both are 0x00, the timer underflows and `mode` returns to 2'b00 (run), and `sys_clk` follows the oscillator clock from then on.
- R6: Reset in any state returns the block to run mode with `osc_en` 1 and `sys_clk` following the oscillator clock. There is no warm-up wait.
- R7: One edge after `wait_req` is sampled in run mode, `mode` reads 2'b01 (wait), `sys_clk` is held at 1 and `osc_en` stays 1.
- R8: An enabled interrupt in wait returns the block to run mode on the next edge, with no counting delay.
- R9: An interrupt request with `irq_en` at 0 leaves stop, warm-up and wait unchanged.
- R10: When `stop_req` and `wait_req` are sampled together in run mode, stop wins.
- R11: Stop and wait requests and counter writes are ignored outside run mode.
- R12: `sys_clk` is 1 whenever `clk_osc` is 1, so that gating only starts or ends while the clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | Stop request from the decoder, sampled in run mode |
| wait_req | input | 1 | Wait request from the decoder, sampled in run mode |
| keep_cnt | input | 1 | 1: no counter preload on entering stop |
| irq_req | input | 1 | External interrupt request |
| irq_en | input | 1 | Enable of that interrupt |
| tmr_wr | input | 1 | Write strobe for the timer |
| tmr_wdata | input | TMR_W | Timer write value |
| psc_wr | input | 1 | Write strobe for the prescaler |
| psc_wdata | input | PSC_W | Prescaler write value |
| osc_en | output | 1 | Oscillator enable |
| sys_clk | output | 1 | Gated system clock, parked high |
| mode | output | 2 | 00 run, 01 wait, 10 stop (including warm-up) |

## Verification
Stop is tried in three forms: with the fixed preload, with small random written counter values under `keep_cnt`, and with both requests at once. The fixed preload must give exactly 512 parked edges. The written values must give the span the formula predicts, which separates a wrong prescaler wrap from a wrong timer decrement, because the prescaler values are random and the timer is 0, 1 or 2. Wait and stop are each left once by interrupt and once by reset, which tells the counted exit apart from the immediate ones. Disabled interrupts, repeated requests and stray writes are issued while parked, and the following exit length shows whether any of them leaked through.

// File: rtl/lp_clk_ctrl.sv
module lp_clk_ctrl #(
  parameter int PSC_W = 8,
  parameter int TMR_W = 8
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             wait_req,
  input  logic             keep_cnt,
  input  logic             irq_req,
  input  logic             irq_en,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             psc_wr,
  input  logic [PSC_W-1:0] psc_wdata,
  output logic             osc_en,
  output logic             sys_clk,
  output logic [1:0]       mode
);
  localparam logic [TMR_W-1:0] TMR_PRE = TMR_W'(1);
  localparam logic [PSC_W-1:0] PSC_PRE = '1;

  typedef enum logic [1:0] {S_RUN, S_WAIT, S_STOP, S_WARM} st_t;

  st_t              st, st_nx;
  logic [TMR_W-1:0] tmr;
  logic [PSC_W-1:0] psc;
  logic             park_q;

  wire wake  = irq_req & irq_en;
  wire uflow = (st == S_WARM) && (tmr == '0) && (psc == '0);

  always_comb begin
    st_nx = st;
    case (st)
      S_RUN:  if (stop_req) st_nx = S_STOP;
              else if (wait_req) st_nx = S_WAIT;
      S_WAIT: if (wake) st_nx = S_RUN;
      S_STOP: if (wake) st_nx = S_WARM;
      S_WARM: if (uflow) st_nx = S_RUN;
      default: st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      park_q <= 1'b0;
      tmr    <= '1;
      psc    <= '1;
    end else begin
      st     <= st_nx;
      park_q <= (st_nx != S_RUN);
      if (st == S_RUN) begin
        if (stop_req) begin
          if (!keep_cnt) begin
            tmr <= TMR_PRE;
            psc <= PSC_PRE;
          end
        end else begin
          if (tmr_wr) tmr <= tmr_wdata;
          if (psc_wr) psc <= psc_wdata;
        end
      end else if (st == S_WARM) begin
        psc <= psc - 1'b1;
        if (psc == '0) tmr <= tmr - 1'b1;
      end
    end
  end

  assign osc_en  = (st != S_STOP);
  assign sys_clk = clk_osc | park_q;
  assign mode    = (st == S_RUN) ? 2'b00 : (st == S_WAIT) ? 2'b01 : 2'b10;

  // R1
  stop_park_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (st == S_RUN && stop_req) |=> (!osc_en && park_q && mode == 2'b10));
  // R2
  preload_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (st == S_RUN && stop_req && !keep_cnt) |=> (tmr == TMR_PRE && psc == PSC_PRE));
  // R3
  keep_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (st == S_RUN && stop_req && keep_cnt) |=> ($stable(tmr) && $stable(psc)));
  // R5
  uflow_release_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    uflow |=> (st == S_RUN && !park_q));
  // R5
  warm_step_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (st == S_WARM && !uflow) |=> (psc == $past(psc) - 1'b1 && st == S_WARM));
  // R8
  wait_exit_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (st == S_WAIT && wake) |=> (st == S_RUN && !park_q));
  // R9
  masked_irq_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ((st == S_WAIT || st == S_STOP) && !irq_en) |=> $stable(st));
  // R11
  no_write_parked_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (st == S_STOP || st == S_WAIT) |=> ($stable(tmr) && $stable(psc)));
endmodule

// File: tb/lp_clk_ctrl_bench.sv
`timescale 1ns/1ps
module lp_clk_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_req = 0, wait_req = 0, keep_cnt = 0, irq_req = 0, irq_en = 0;
  logic tmr_wr = 0, psc_wr = 0;
  logic [7:0] tmr_wdata = 0, psc_wdata = 0;
  logic osc_en, sys_clk;
  logic [1:0] mode;
  int checks = 0, fails = 0;
  int tmr_m = 255, psc_m = 255;
  bit  done = 0;

  always #2.5 clk = ~clk;

  lp_clk_ctrl u_lp_clk_ctrl (
    .clk_osc(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .keep_cnt(keep_cnt), .irq_req(irq_req), .irq_en(irq_en),
    .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .psc_wr(psc_wr), .psc_wdata(psc_wdata),
    .osc_en(osc_en), .sys_clk(sys_clk), .mode(mode));

  function automatic int warm_len(int t, int p);
    return p + 1 + 256 * t;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic state_chk(string tag, int m, int osc, int park);
    chk(mode == 2'(m), tag, "mode", int'(mode), m);
    chk(osc_en == 1'(osc), tag, "osc_en", int'(osc_en), osc);
    chk(sys_clk == 1'(park), tag, "sys_clk at low phase", int'(sys_clk), park);
  endtask

  task automatic high_chk(string tag);
    @(posedge clk); #1;
    chk(sys_clk == 1'b1, tag, "sys_clk during high phase", int'(sys_clk), 1);
    tick();
  endtask

  task automatic do_reset(string tag);
    rst_n = 0; tick(); rst_n = 1;
    tmr_m = 255; psc_m = 255;
    state_chk(tag, 0, 1, 0);
    high_chk("R12");
  endtask

  task automatic masked_irq(int n);
    irq_req = 1; irq_en = 0;
    repeat (n) tick();
    irq_req = 0;
  endtask

  task automatic stray_inputs();
    stop_req = 1; wait_req = 1; tmr_wr = 1; psc_wr = 1;
    tmr_wdata = 8'($urandom); psc_wdata = 8'($urandom);
    tick();
    stop_req = 0; wait_req = 0; tmr_wr = 0; psc_wr = 0;
  endtask

  task automatic enter_stop(bit keep, bit both);
    keep_cnt = keep; stop_req = 1; wait_req = both;
    tick();
    stop_req = 0; wait_req = 0;
    if (!keep) begin tmr_m = 1; psc_m = 255; end
    state_chk(both ? "R10" : "R1", 2, 0, 1);
  endtask

  task automatic irq_exit_stop(string tag);
    int n = warm_len(tmr_m, psc_m);
    irq_req = 1; irq_en = 1;
    tick();
    irq_req = 0; irq_en = 0;
    state_chk("R4", 2, 1, 1);
    repeat (n - 1) tick();
    state_chk(tag, 2, 1, 1);
    tick();
    state_chk("R5", 0, 1, 0);
    tmr_m = 255; psc_m = 255;
  endtask

  task automatic write_cnt(int t, int p);
    tmr_wr = 1; psc_wr = 1; tmr_wdata = 8'(t); psc_wdata = 8'(p);
    tick();
    tmr_wr = 0; psc_wr = 0;
    tmr_m = t; psc_m = p;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (2) tick();
    state_chk("R6", 0, 1, 0);
    rst_n = 1; tick();
    state_chk("R6", 0, 1, 0);
    high_chk("R12");

    enter_stop(0, 0);
    high_chk("R12");
    irq_exit_stop("R2");

    write_cnt(0, 0);
    enter_stop(1, 0);
    irq_exit_stop("R3");

    write_cnt(2, 7);
    enter_stop(1, 0);
    masked_irq(3);
    state_chk("R9", 2, 0, 1);
    irq_exit_stop("R3");

    for (int it = 0; it < 40; it++) begin
      int r = int'($urandom % 6);
      case (r)
        0: begin enter_stop(0, 0); irq_exit_stop("R2"); end
        1: begin
          write_cnt(int'($urandom % 3), int'($urandom % 256));
          enter_stop(1, 0);
          masked_irq(1 + int'($urandom % 4));
          state_chk("R9", 2, 0, 1);
          stray_inputs();
          state_chk("R11", 2, 0, 1);
          irq_exit_stop("R3");
        end
        2: begin
          enter_stop(int'($urandom % 2) == 1 ? 1'b0 : 1'b0, 0);
          if ($urandom % 2) begin
            irq_req = 1; irq_en = 1; tick(); irq_req = 0; irq_en = 0;
            repeat (int'($urandom % 20)) tick();
            state_chk("R4", 2, 1, 1);
          end
          do_reset("R6");
        end
        3: begin
          wait_req = 1; tick(); wait_req = 0;
          state_chk("R7", 1, 1, 1);
          high_chk("R12");
          masked_irq(1 + int'($urandom % 3));
          state_chk("R9", 1, 1, 1);
          stray_inputs();
          state_chk("R11", 1, 1, 1);
          irq_req = 1; irq_en = 1; tick(); irq_req = 0; irq_en = 0;
          state_chk("R8", 0, 1, 0);
        end
        4: begin
          wait_req = 1; tick(); wait_req = 0;
          state_chk("R7", 1, 1, 1);
          do_reset("R6");
        end
        default: begin enter_stop(0, 1); irq_exit_stop("R2"); end
      endcase
      irq_req = 1; irq_en = 1; tick(); irq_req = 0; irq_en = 0;
      state_chk("R11", 0, 1, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule